// File: doc/BRIEF.md
# Serial Configuration EEPROM Autoload Controller

This block is the master side of a four-wire serial EEPROM link: chip select, serial clock, data toward the device and data from it. When reset is released it fetches a fixed list of 16-bit configuration words into a bank of registers. It then serves single-word reads for a host. The first read of the list also finds out the size of the attached device. The device answers with a zero bit once it has taken its whole address field, and the position of that bit tells a 64-word part (6 address bits) from a 256-word part (8 address bits).

The list always covers words 0h, 1h, 2h, Ah and Dh. If bit 0 of word Ah reads as one, six more words are fetched: Bh, Ch, FBh, FCh, FDh and FEh. While the list is being fetched, and while any transfer is still on the wire, a host request is not served. It gets a one-cycle retry answer instead. The serial clock comes from the system clock through a divider set by a parameter.

Top module: `eeprom_autoload`

## Requirements
- R1: Each transfer holds `mw_cs` high from start to end, and `mw_sclk` is low whenever `mw_cs` is low. The first three bits on `mw_mosi` are 1, 1, 0 (a start bit, then the read code 10). The address follows, most significant bit first.
- R2: `mw_mosi` changes only while `mw_sclk` is low. `mw_miso` is sampled when `mw_sclk` rises. One serial clock period is 2*HALF_DIV system clocks.
- R3: The first transfer (word 0) sends zero address bits until `mw_miso` reads 0. If that zero follows 6 address bits, `size_256` is 0 and every later transfer sends 6 address bits (the low 6 of the word number). If it follows 8 bits, `size_256` is 1 and later transfers send 8 address bits.
- R4: If `mw_miso` is still 1 at the sample taken after the 8th address bit, `size_err` and `size_256` are both set, and 8-bit addressing is used from then on.
- R5: The 16 data bits come after the dummy zero, most significant bit first.
- R6: The autoload writes words 0h, 1h, 2h, Ah and Dh into slots 0 to 4. Slot i appears on `word_bank[16*i+15:16*i]`.
- R7: If bit 0 of word Ah is 1, words Bh, Ch, FBh, FCh, FDh and FEh fill slots 5 to 10. If that bit is 0, slots 5 to 10 stay zero and no further transfer is made.
- R8: `load_done` rises once the last word of the list is stored, and it stays high until reset.
- R9: A `host_req` seen while `load_done` is low, or while a transfer or its chip-select gap is still running, gives a one-cycle `host_retry` in the next cycle and starts no read.
- R10: A `host_req` seen with `load_done` high and no transfer running starts a read of `host_addr`. On completion `host_valid` pulses for one cycle, and `host_data` holds the word.
- R11: `mw_cs` stays low for at least 2*HALF_DIV system clocks between two transfers.
- R12: During reset `mw_cs`, `mw_sclk`, `mw_mosi`, `host_retry`, `host_valid`, `load_done`, `size_256` and `size_err` are 0, and `word_bank` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mw_cs | output | 1 | EEPROM chip select, active high |
| mw_sclk | output | 1 | EEPROM serial clock |
| mw_mosi | output | 1 | Serial data toward the EEPROM |
| mw_miso | input | 1 | Serial data from the EEPROM |
| host_req | input | 1 | One-cycle host read request |
| host_addr | input | 8 | Word number for a host read |
| host_retry | output | 1 | Request refused, try again (one cycle) |
| host_valid | output | 1 | Host read finished (one cycle) |
| host_data | output | 16 | Word from the last host read |
| load_done | output | 1 | Autoload list complete |
| size_256 | output | 1 | 1 = 8-bit addressing, 0 = 6-bit |
| size_err | output | 1 | No dummy zero seen during detection |
| word_bank | output | 176 | Autoloaded words, slot i at bits 16*i+15:16*i |

## Verification
The bench runs a behavioural EEPROM in both sizes.

- **Address width.** It checks that the high list words (FBh to FEh) come back correctly from each size. A design that gets the width wrong would shift the address bits, and those slots would show aliased or garbage words.
- **Extension flag.** It clears the flag bit in word Ah. A design that ignores the flag would fill slots 5 to 10, which must stay zero.
- **Silent device.** It attaches a device that never returns the dummy zero. A design without the fallback would hang or report the small size instead of flagging the error.
- **Host requests.** It sends requests during the autoload window and during a running host read. A controller that served them there would corrupt a transfer on the wire or lose the retry answer.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned SLOT_CNT  = 11;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned RISE_W    = 6;
  localparam int unsigned BASE_LAST = 4;   // last slot of the unconditional list
  localparam int unsigned FLAG_SLOT = 3;   // slot holding word Ah

  typedef logic [RISE_W-1:0] rise_t;
  typedef enum logic [1:0] {XF_IDLE, XF_RUN, XF_GAP} xf_state_e;
  typedef enum logic [1:0] {SQ_ISSUE, SQ_FETCH, SQ_READY, SQ_HOST} sq_state_e;

  // word number fetched into each slot
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
    logic [ADDR_W-1:0] a;
    case (s)
      4'd0:    a = 8'h00;
      4'd1:    a = 8'h01;
      4'd2:    a = 8'h02;
      4'd3:    a = 8'h0A;
      4'd4:    a = 8'h0D;
      4'd5:    a = 8'h0B;
      4'd6:    a = 8'h0C;
      4'd7:    a = 8'hFB;
      4'd8:    a = 8'hFC;
      4'd9:    a = 8'hFD;
      4'd10:   a = 8'hFE;
      default: a = 8'h00;
    endcase
    return a;
  endfunction

  // rising edge at which the dummy zero is sampled (3 header bits + address)
  function automatic rise_t dummy_rise(input logic [3:0] abits);
    return rise_t'(abits) + rise_t'(4);
  endfunction

  // rising edge that samples data bit 0
  function automatic rise_t final_rise(input logic [3:0] abits);
    return dummy_rise(abits) + rise_t'(WORD_W);
  endfunction

  // bit presented on the data line ahead of rising edge number idx (from 1)
  function automatic logic mosi_bit(input rise_t idx, input logic [ADDR_W-1:0] addr,
                                    input logic [3:0] abits);
    logic [3:0] k;
    logic       b;
    b = 1'b0;
    if (idx == rise_t'(1) || idx == rise_t'(2)) begin
      b = 1'b1;
    end else if (idx >= rise_t'(4) && idx < dummy_rise(abits)) begin
      k = abits - 4'd1 - 4'(idx - rise_t'(4));
      b = |(addr & (8'b1 << k));
    end
    return b;
  endfunction

  function automatic logic is_last_slot(input logic [SLOT_W-1:0] s, input logic ext);
    return (s == SLOT_W'(SLOT_CNT - 1)) || (!ext && s == SLOT_W'(BASE_LAST));
  endfunction
endpackage

// File: rtl/ee_tick_gen.sv
module ee_tick_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] WRAP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == WRAP)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == WRAP);
endmodule

// File: rtl/ee_xfer.sv
module ee_xfer import ee_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        abits,
  input  logic              detect,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic [3:0]        abits_used,
  output logic              no_zero,
  output logic              cs,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  xf_state_e         st;
  rise_t             nrise;
  logic [3:0]        a_cur;
  logic              found;
  logic              err;
  logic              gap_half;
  logic [WORD_W-1:0] shreg;
  logic [ADDR_W-1:0] addr_q;

  // named events
  rise_t n_next;
  logic  rise_ev, fall_ev, last_fall, in_window, zero_seen, window_end;
  assign n_next     = nrise + rise_t'(1);
  assign rise_ev    = (st == XF_RUN) && tick && !sclk;
  assign fall_ev    = (st == XF_RUN) && tick && sclk;
  assign last_fall  = fall_ev && (nrise == final_rise(a_cur));
  assign in_window  = rise_ev && !found && n_next >= rise_t'(5) && n_next <= dummy_rise(4'd8);
  assign zero_seen  = in_window && !miso;
  assign window_end = in_window && miso && (n_next == dummy_rise(4'd8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= XF_IDLE; cs <= 1'b0; sclk <= 1'b0; mosi <= 1'b0;
      nrise <= '0; a_cur <= 4'd8; found <= 1'b0; err <= 1'b0;
      gap_half <= 1'b0; shreg <= '0; addr_q <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        XF_IDLE: if (start) begin
          st <= XF_RUN; cs <= 1'b1; sclk <= 1'b0; mosi <= 1'b1;
          nrise <= '0; addr_q <= addr; a_cur <= detect ? 4'd8 : abits;
          found <= !detect; err <= 1'b0;
        end
        XF_RUN: begin
          if (rise_ev) begin
            sclk  <= 1'b1;
            nrise <= n_next;
            if (zero_seen) begin
              found <= 1'b1;
              a_cur <= 4'(n_next - rise_t'(4));
            end else if (window_end) begin
              found <= 1'b1;
              err   <= 1'b1;
            end
            if (n_next > dummy_rise(a_cur)) shreg <= {shreg[WORD_W-2:0], miso};
          end
          if (fall_ev) begin
            sclk <= 1'b0;
            if (last_fall) begin
              cs <= 1'b0; mosi <= 1'b0; st <= XF_GAP; gap_half <= 1'b0; done <= 1'b1;
            end else begin
              mosi <= mosi_bit(n_next, addr_q, a_cur);
            end
          end
        end
        XF_GAP: if (tick) begin
          if (gap_half) st <= XF_IDLE;
          else          gap_half <= 1'b1;
        end
        default: st <= XF_IDLE;
      endcase
    end
  end

  assign busy       = (st != XF_IDLE);
  assign rdata      = shreg;
  assign abits_used = a_cur;
  assign no_zero    = err;
endmodule

// File: rtl/ee_seq.sv
module ee_seq import ee_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xf_busy,
  input  logic              xf_done,
  input  logic [WORD_W-1:0] xf_rdata,
  input  logic [3:0]        xf_abits,
  input  logic              xf_err,
  output logic              xf_start,
  output logic [ADDR_W-1:0] xf_addr,
  output logic [3:0]        xf_abits_req,
  output logic              xf_detect,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_retry,
  output logic              host_valid,
  output logic [WORD_W-1:0] host_data,
  output logic              load_done,
  output logic              size_256,
  output logic              size_err,
  output logic              bank_we,
  output logic [SLOT_W-1:0] bank_sel,
  output logic [WORD_W-1:0] bank_wdata
);
  sq_state_e         st;
  logic [SLOT_W-1:0] slot;
  logic [3:0]        abits_q;
  logic              ext_q;
  logic              host_ok;

  assign host_ok      = (st == SQ_READY) && !xf_busy;
  assign xf_start     = ((st == SQ_ISSUE) && !xf_busy) || (host_ok && host_req);
  assign xf_addr      = (st == SQ_READY) ? host_addr : slot_addr(slot);
  assign xf_abits_req = abits_q;
  assign xf_detect    = (st == SQ_ISSUE) && (slot == '0);
  assign bank_we      = (st == SQ_FETCH) && xf_done;
  assign bank_sel     = slot;
  assign bank_wdata   = xf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_ISSUE; slot <= '0; abits_q <= 4'd8; ext_q <= 1'b0;
      load_done <= 1'b0; size_256 <= 1'b0; size_err <= 1'b0;
      host_retry <= 1'b0; host_valid <= 1'b0; host_data <= '0;
    end else begin
      host_retry <= host_req && !host_ok;
      host_valid <= 1'b0;
      case (st)
        SQ_ISSUE: if (!xf_busy) st <= SQ_FETCH;
        SQ_FETCH: if (xf_done) begin
          if (slot == '0) begin
            abits_q  <= xf_abits;
            size_256 <= (xf_abits == 4'd8);
            size_err <= xf_err;
          end
          if (slot == SLOT_W'(FLAG_SLOT)) ext_q <= xf_rdata[0];
          if (is_last_slot(slot, ext_q)) begin
            st <= SQ_READY;
            load_done <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
            st   <= SQ_ISSUE;
          end
        end
        SQ_READY: if (host_req && !xf_busy) st <= SQ_HOST;
        SQ_HOST: if (xf_done) begin
          host_valid <= 1'b1;
          host_data  <= xf_rdata;
          st <= SQ_READY;
        end
        default: st <= SQ_ISSUE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload import ee_pkg::*; #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         mw_cs,
  output logic                         mw_sclk,
  output logic                         mw_mosi,
  input  logic                         mw_miso,
  input  logic                         host_req,
  input  logic [ADDR_W-1:0]            host_addr,
  output logic                         host_retry,
  output logic                         host_valid,
  output logic [WORD_W-1:0]            host_data,
  output logic                         load_done,
  output logic                         size_256,
  output logic                         size_err,
  output logic [SLOT_CNT*WORD_W-1:0]   word_bank
);
  logic              xfer_busy, xfer_done, xfer_tick, xfer_start, xfer_detect, xfer_err;
  logic [ADDR_W-1:0] xfer_addr;
  logic [3:0]        xfer_abits_req, xfer_abits_used;
  logic [WORD_W-1:0] xfer_rdata;
  logic              bank_we;
  logic [SLOT_W-1:0] bank_sel;
  logic [WORD_W-1:0] bank_wdata;

  ee_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(xfer_busy), .tick(xfer_tick)
  );

  ee_xfer xfer_i (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .addr(xfer_addr),
    .abits(xfer_abits_req), .detect(xfer_detect), .tick(xfer_tick),
    .busy(xfer_busy), .done(xfer_done), .rdata(xfer_rdata),
    .abits_used(xfer_abits_used), .no_zero(xfer_err),
    .cs(mw_cs), .sclk(mw_sclk), .mosi(mw_mosi), .miso(mw_miso)
  );

  ee_seq seq_i (
    .clk(clk), .rst_n(rst_n), .xf_busy(xfer_busy), .xf_done(xfer_done),
    .xf_rdata(xfer_rdata), .xf_abits(xfer_abits_used), .xf_err(xfer_err),
    .xf_start(xfer_start), .xf_addr(xfer_addr), .xf_abits_req(xfer_abits_req),
    .xf_detect(xfer_detect), .host_req(host_req), .host_addr(host_addr),
    .host_retry(host_retry), .host_valid(host_valid), .host_data(host_data),
    .load_done(load_done), .size_256(size_256), .size_err(size_err),
    .bank_we(bank_we), .bank_sel(bank_sel), .bank_wdata(bank_wdata)
  );

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (bank_we && bank_sel == SLOT_W'(g)) q <= bank_wdata;
    end
    assign word_bank[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/ee_autoload_chk.sv
module ee_autoload_chk (
  input logic clk,
  input logic rst_n,
  input logic mw_cs,
  input logic mw_sclk,
  input logic mw_mosi,
  input logic host_req,
  input logic host_retry,
  input logic host_valid,
  input logic load_done,
  input logic size_256,
  input logic size_err,
  input logic xfer_done,
  input logic xfer_busy
);
  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_cs |-> !mw_sclk);                                                  // R1
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mw_cs |-> xfer_busy);                                                  // R1
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sclk && $past(mw_sclk)) |-> $stable(mw_mosi));                    // R2
  AST_ERR_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> size_256);                                                // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);                                              // R8
  AST_RETRY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !load_done) |=> host_retry);                              // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> !host_valid);                                           // R10
  AST_DONE_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !mw_cs);                                                 // R11
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |=> !mw_cs);                                              // R11
endmodule

bind eeprom_autoload ee_autoload_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sclk(mw_sclk), .mw_mosi(mw_mosi),
  .host_req(host_req), .host_retry(host_retry), .host_valid(host_valid),
  .load_done(load_done), .size_256(size_256), .size_err(size_err),
  .xfer_done(xfer_done), .xfer_busy(xfer_busy)
);

// File: tb/eeprom_autoload_tb_top.sv
module eeprom_autoload_tb_top;
  localparam int HALF = 4;
  localparam int NSLOT = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mw_cs, mw_sclk, mw_mosi, mw_miso;
  logic         host_req = 1'b0;
  logic [7:0]   host_addr = 8'h00;
  logic         host_retry, host_valid, load_done, size_256, size_err;
  logic [15:0]  host_data;
  logic [NSLOT*16-1:0] word_bank;

  always #10 clk = ~clk;

  eeprom_autoload #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sclk(mw_sclk), .mw_mosi(mw_mosi),
    .mw_miso(mw_miso), .host_req(host_req), .host_addr(host_addr),
    .host_retry(host_retry), .host_valid(host_valid), .host_data(host_data),
    .load_done(load_done), .size_256(size_256), .size_err(size_err),
    .word_bank(word_bank)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural serial EEPROM ----------------
  int         m_size = 256;
  bit         m_mute = 1'b0;
  bit         m_flag = 1'b1;
  int         m_cnt = 0;
  int         m_badop = 0;
  logic [2:0] m_op = '0;
  logic [7:0] m_addr = '0;
  logic       m_miso = 1'b1;
  assign mw_miso = m_miso;

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    logic [15:0] v;
    v = {a ^ 8'h5A, ~a};
    if (a == 8'h0A) v[0] = m_flag;
    return v;
  endfunction

  function automatic int abw();
    return (m_size == 256) ? 8 : 6;
  endfunction

  always @(posedge mw_cs) begin
    m_cnt = 0; m_op = '0; m_addr = '0; m_miso = 1'b1;
  end

  always @(posedge mw_sclk) if (mw_cs) begin
    m_cnt++;
    if (m_cnt <= 3) m_op = {m_op[1:0], mw_mosi};
    if (m_cnt == 3 && m_op != 3'b110) m_badop++;
    if (m_cnt >= 4 && m_cnt < 4 + abw()) m_addr = {m_addr[6:0], mw_mosi};
  end

  always @(negedge mw_sclk) if (mw_cs && !m_mute) begin
    logic [15:0] w;
    w = mem_word(m_addr);
    if (m_cnt == 3 + abw())                          m_miso = 1'b0;
    else if (m_cnt >= 4 + abw() && m_cnt < 20 + abw()) m_miso = w[15 - (m_cnt - 4 - abw())];
    else                                              m_miso = 1'b1;
  end

  // ---------------- line monitors ----------------
  int   gap_run = 0, gap_min = 1000, mosi_bad = 0;
  bit   seen_cs = 1'b0;
  logic p_sclk = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) begin
    if (!mw_cs) gap_run++;
    else begin
      if (seen_cs && gap_run > 0 && gap_run < gap_min) gap_min = gap_run;
      gap_run = 0;
      seen_cs = 1'b1;
    end
    if (rst_n && mw_sclk && p_sclk && mw_mosi != p_mosi) mosi_bad++;
    p_sclk = mw_sclk; p_mosi = mw_mosi;
  end

  localparam logic [7:0] SLOT_ADDR [NSLOT] =
    '{8'h00, 8'h01, 8'h02, 8'h0A, 8'h0D, 8'h0B, 8'h0C, 8'hFB, 8'hFC, 8'hFD, 8'hFE};

  // ---------------- helpers ----------------
  task automatic do_reset(input int size, input bit mute, input bit flag, input bit check);
    m_size = size; m_mute = mute; m_flag = flag; m_badop = 0; m_miso = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; host_req = 1'b0;
    repeat (4) @(negedge clk);
    if (check) begin
      chk(mw_cs == 0 && mw_sclk == 0 && mw_mosi == 0, "R12", "serial lines in reset", {mw_cs, mw_sclk, mw_mosi}, 0);
      chk(load_done == 0 && size_256 == 0 && size_err == 0, "R12", "flags in reset", {load_done, size_256, size_err}, 0);
      chk(host_retry == 0 && host_valid == 0, "R12", "host strobes in reset", {host_retry, host_valid}, 0);
      chk(word_bank == '0, "R12", "bank in reset", 32'(|word_bank), 0);
    end
    gap_run = 0; gap_min = 1000; seen_cs = 1'b0; mosi_bad = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int i;
    for (i = 0; i < 20000 && !load_done; i++) @(negedge clk);
    chk(load_done == 1'b1, "R8", "load_done after autoload", 32'(load_done), 1);
  endtask

  task automatic check_bank(input string req);
    bit ext;
    logic [7:0] mask;
    ext  = m_mute ? 1'b1 : m_flag;
    mask = (m_size == 256) ? 8'hFF : 8'h3F;
    for (int i = 0; i < NSLOT; i++) begin
      logic [15:0] e, a;
      a = word_bank[i*16 +: 16];
      if (m_mute)              e = 16'hFFFF;
      else if (i < 5 || ext)   e = mem_word(SLOT_ADDR[i] & mask);
      else                     e = 16'h0000;
      chk(a == e, req, $sformatf("slot %0d", i), 32'(a), 32'(e));
    end
  endtask

  task automatic host_read(input logic [7:0] a, input logic [15:0] e, input string req);
    int i;
    repeat (4 * HALF + 4) @(negedge clk);
    host_addr = a; host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_retry == 1'b0, req, "no retry when idle", 32'(host_retry), 0);
    for (i = 0; i < 2000 && !host_valid; i++) @(negedge clk);
    chk(host_valid == 1'b1, req, "host_valid pulse", 32'(host_valid), 1);
    chk(host_data == e, req, $sformatf("host word %0h", a), 32'(host_data), 32'(e));
    @(negedge clk);
    chk(host_valid == 1'b0, req, "host_valid one cycle", 32'(host_valid), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_load_256_ext();
    time t1, t2;
    do_reset(256, 1'b0, 1'b1, 1'b1);
    @(posedge mw_sclk); t1 = $time;
    @(posedge mw_sclk); t2 = $time;
    chk((t2 - t1) / 20 == 2 * HALF, "R2", "serial clock period", 32'((t2 - t1) / 20), 2 * HALF);
    wait_done();
    chk(size_256 == 1'b1 && size_err == 1'b0, "R3", "256-word detect", {size_256, size_err}, 2'b10);
    check_bank("R7");
    chk(m_badop == 0, "R1", "start bit and read code", m_badop, 0);
    chk(mosi_bad == 0, "R2", "mosi change while sclk high", mosi_bad, 0);
    chk(gap_min >= 2 * HALF, "R11", "chip select gap", gap_min, 2 * HALF);
    repeat (50) @(negedge clk);
    chk(load_done == 1'b1, "R8", "load_done held", 32'(load_done), 1);
  endtask

  task automatic t_load_256_base();
    do_reset(256, 1'b0, 1'b0, 1'b0);
    wait_done();
    check_bank("R6");
    chk(word_bank[5*16 +: 16] == 16'h0, "R7", "flag clear leaves slot 5", 32'(word_bank[5*16 +: 16]), 0);
  endtask

  task automatic t_load_64();
    do_reset(64, 1'b0, 1'b1, 1'b0);
    wait_done();
    chk(size_256 == 1'b0 && size_err == 1'b0, "R3", "64-word detect", {size_256, size_err}, 2'b00);
    check_bank("R5");
    chk(m_badop == 0, "R1", "read code 64-word", m_badop, 0);
    host_read(8'hC5, mem_word(8'h05), "R10");
  endtask

  task automatic t_mute();
    do_reset(256, 1'b1, 1'b1, 1'b0);
    wait_done();
    chk(size_err == 1'b1 && size_256 == 1'b1, "R4", "no dummy zero", {size_err, size_256}, 2'b11);
    chk(word_bank[15:0] == 16'hFFFF, "R4", "slot 0 with silent part", 32'(word_bank[15:0]), 32'hFFFF);
  endtask

  task automatic t_retry();
    int i;
    bit got;
    do_reset(256, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    host_addr = 8'h37; host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_retry == 1'b1, "R9", "retry during autoload", 32'(host_retry), 1);
    @(negedge clk);
    chk(host_retry == 1'b0, "R9", "retry one cycle", 32'(host_retry), 0);
    got = 1'b0;
    for (i = 0; i < 20000 && !load_done; i++) begin
      @(negedge clk);
      if (host_valid) got = 1'b1;
    end
    chk(got == 1'b0, "R9", "refused request produced no read", 32'(got), 0);
    host_read(8'h37, mem_word(8'h37), "R10");
    repeat (4 * HALF + 4) @(negedge clk);
    host_addr = 8'h10; host_req = 1'b1;
    @(negedge clk);
    host_addr = 8'h20;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_retry == 1'b1, "R9", "retry during host read", 32'(host_retry), 1);
    for (i = 0; i < 2000 && !host_valid; i++) @(negedge clk);
    chk(host_data == mem_word(8'h10), "R10", "first request served", 32'(host_data), 32'(mem_word(8'h10)));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_load_256_ext();
    t_load_256_base();
    t_load_64();
    t_mute();
    t_retry();
    summary();
    $finish;
  end
endmodule